// File: doc/BRIEF.md
# Kernel-Only Loop Branch Controller

This block sits beside the branch unit of a core that runs modulo-scheduled loops as a single kernel body. Before the loop, software loads two counts: how many source iterations the loop has and how many pipeline stages the schedule was cut into. Every time the loop-closing branch executes, the block decides whether to go back to the top of the kernel. It also rotates a vector of stage-enable predicates, so the same kernel code first fills the software pipeline, then runs at full width, and finally drains it.

Two counters are chained. The iteration counter runs first and shifts a 1 into predicate bit 0 on each pass. When it reaches zero, the stage counter takes over and shifts in 0s so that the stages empty one after another. A rotating register base steps down by one on every taken branch and wraps around the rotating file. Operations in stage k are guarded by predicate bit k. A loop of N iterations and S stages therefore runs the kernel N+S-1 times, and with an initiation interval of II it takes II·(N+S-1) cycles.

Top module: `swp_loop_ctrl`

## Requirements
- R1: A load (`load_i`=1 on a clock edge) arms the loop. The iteration counter is set to `trip_i`-1 and the stage counter to `stages_i`-1, with a value of 0 on either input treated as 1. From the next cycle `pred_o` equals 1 (only bit 0 set) and `rrb_o` equals 0.
- R2: On a branch strobe while the loop is armed and the iteration counter is nonzero, the counter decrements, a 1 enters predicate bit 0, and `taken_o` is 1 in the following cycle.
- R3: On a branch strobe while armed, with the iteration counter at zero and the stage counter nonzero, the stage counter decrements, a 0 enters predicate bit 0, and `taken_o` is 1 in the following cycle.
- R4: On a branch strobe while armed with both counters at zero, `taken_o` is 0 and `done_o` is 1 for exactly one cycle (the cycle after the strobe). The loop is then disarmed.
- R5: On every taken branch, predicate bit i moves to bit i+1, and the old top bit is discarded. After the taken branch that starts kernel pass p (the loaded state is p=0), bit k of `pred_o` is 1 exactly when 0 ≤ p-k < N.
- R6: `rrb_o` decreases by one on every taken branch and wraps modulo 2^RRB_W.
- R7: A loop of N iterations and S stages produces N+S-2 taken branches followed by one fall-through. With N=4 and S=4, the bit strings P0..P3 seen across the 7 passes are 1000, 1100, 1110, 1111, 0111, 0011, 0001.
- R8: A branch strobe while no loop is armed gives `taken_o`=0 and `done_o`=0, and leaves `pred_o` and `rrb_o` unchanged.
- R9: When a load and a branch strobe arrive in the same cycle, the load wins: the outcome is that of R1, and `taken_o` is 0.
- R10: After the fall-through, `pred_o` and `rrb_o` hold their last values until the next load.
- R11: After reset, `pred_o`=0, `rrb_o`=0, `taken_o`=0, `done_o`=0, and the loop is disarmed.
- R12: With one strobe every II cycles, a loop of 100 iterations, 3 stages and II=2 takes 204 cycles from the load to the fall-through branch, counted inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Arm a new loop with the counts below |
| trip_i | input | CNT_W | Number of source iterations N |
| stages_i | input | CNT_W | Number of pipeline stages S |
| br_i | input | 1 | Loop-closing branch executes this cycle |
| taken_o | output | 1 | Registered decision for the last strobe: 1 = back to the top |
| done_o | output | 1 | One-cycle pulse after the fall-through branch |
| pred_o | output | PRED_W | Stage-enable predicates, bit k guards stage k |
| rrb_o | output | RRB_W | Rotating register base |

## Verification
A counter that is off by one shows up at the ports as an extra or missing taken branch, and as a predicate pattern that ends one pass early or late. The bench catches this at the fall-through of the loop, or at the first pass whose pattern differs from the closed-form model. A wrong injected bit or a broken shift shows up in `pred_o` in the cycle right after the strobe that caused it. A stale armed flag shows up as a taken answer, or a predicate change, on a stray strobe after the loop has exited. Because every pass is compared against the expected pattern and base value, none of these faults can go unseen for more than one branch.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_FILL  = 2'd1,
    ACT_DRAIN = 2'd2,
    ACT_EXIT  = 2'd3
  } swp_act_e;
endpackage

// File: rtl/swp_trip_counters.sv
module swp_trip_counters
  import swp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] trip_i,
  input  logic [CNT_W-1:0] stages_i,
  input  logic             br_i,
  input  logic             active_i,
  output swp_act_e         act_o
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] lc_q, lc_d, esc_q, esc_d;
  swp_act_e         act;

  // branch resolution: loop counter first, then epilog counter
  always_comb begin
    act = ACT_IDLE;
    if (br_i && active_i && !load_i) begin
      if (lc_q != '0)       act = ACT_FILL;
      else if (esc_q != '0) act = ACT_DRAIN;
      else                  act = ACT_EXIT;
    end
  end

  always_comb begin
    lc_d  = lc_q;
    esc_d = esc_q;
    if (load_i) begin
      lc_d  = (trip_i   == '0) ? '0 : trip_i   - ONE_C;
      esc_d = (stages_i == '0) ? '0 : stages_i - ONE_C;
    end else if (act == ACT_FILL) begin
      lc_d  = lc_q - ONE_C;
    end else if (act == ACT_DRAIN) begin
      esc_d = esc_q - ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q  <= '0;
      esc_q <= '0;
    end else begin
      lc_q  <= lc_d;
      esc_q <= esc_d;
    end
  end

  assign act_o = act;

  a_r2_lc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_FILL) |=> (lc_q == $past(lc_q) - ONE_C) && $stable(esc_q));

  a_r3_esc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_DRAIN) |=> (esc_q == $past(esc_q) - ONE_C) && (lc_q == '0));

  a_r4_exit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXIT) |=> (lc_q == '0) && (esc_q == '0));
endmodule

// File: rtl/swp_pred_rotator.sv
module swp_pred_rotator
  import swp_pkg::*;
#(
  parameter int PRED_W = 8,
  parameter int RRB_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  swp_act_e          act_i,
  output logic [PRED_W-1:0] pred_o,
  output logic [RRB_W-1:0]  rrb_o
);
  localparam logic [PRED_W-1:0] PRED_SEED = PRED_W'(1);
  localparam logic [RRB_W-1:0]  RRB_ONE   = RRB_W'(1);

  logic [PRED_W-1:0] pred_q, pred_d, shifted;
  logic [RRB_W-1:0]  rrb_q, rrb_d;
  logic              rotate;

  assign rotate     = (act_i == ACT_FILL) || (act_i == ACT_DRAIN);
  assign shifted[0] = (act_i == ACT_FILL);

  // each stage predicate takes its lower neighbour on rotation
  for (genvar i = 1; i < PRED_W; i++) begin : g_shift
    assign shifted[i] = pred_q[i-1];
  end

  always_comb begin
    pred_d = pred_q;
    rrb_d  = rrb_q;
    if (load_i) begin
      pred_d = PRED_SEED;
      rrb_d  = '0;
    end else if (rotate) begin
      pred_d = shifted;
      rrb_d  = rrb_q - RRB_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      rrb_q  <= '0;
    end else begin
      pred_q <= pred_d;
      rrb_q  <= rrb_d;
    end
  end

  assign pred_o = pred_q;
  assign rrb_o  = rrb_q;

  a_r1_seed: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (pred_q == PRED_SEED) && (rrb_q == '0));

  a_r2_inject_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_FILL) |=> pred_q[0]);

  a_r3_inject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && act_i == ACT_DRAIN) |=> !pred_q[0]);

  a_r5_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && rotate) |=> pred_q[PRED_W-1:1] == $past(pred_q[PRED_W-2:0]));

  a_r6_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && rotate) |=> rrb_q == $past(rrb_q) - RRB_ONE);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !rotate) |=> $stable(pred_q) && $stable(rrb_q));
endmodule

// File: rtl/swp_loop_ctrl.sv
module swp_loop_ctrl
  import swp_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRED_W = 8,
  parameter int RRB_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  trip_i,
  input  logic [CNT_W-1:0]  stages_i,
  input  logic              br_i,
  output logic              taken_o,
  output logic              done_o,
  output logic [PRED_W-1:0] pred_o,
  output logic [RRB_W-1:0]  rrb_o
);
  swp_act_e act;
  logic     active_q, active_d;
  logic     taken_q, taken_d;
  logic     done_q, done_d;

  swp_trip_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .trip_i   (trip_i),
    .stages_i (stages_i),
    .br_i     (br_i),
    .active_i (active_q),
    .act_o    (act)
  );

  swp_pred_rotator #(.PRED_W(PRED_W), .RRB_W(RRB_W)) u_rot (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .act_i  (act),
    .pred_o (pred_o),
    .rrb_o  (rrb_o)
  );

  always_comb begin
    active_d = active_q;
    if (load_i)                active_d = 1'b1;
    else if (act == ACT_EXIT)  active_d = 1'b0;
    taken_d = (act == ACT_FILL) || (act == ACT_DRAIN);
    done_d  = (act == ACT_EXIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      taken_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      taken_q  <= taken_d;
      done_q   <= done_d;
    end
  end

  assign taken_o = taken_q;
  assign done_o  = done_q;

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_done_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !taken_o);

  a_r8_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (br_i && !active_q && !load_i) |=> !taken_o && !done_o && $stable(pred_o));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && br_i) |=> !taken_o && !done_o && active_q);
endmodule

// File: tb/sim_swp_loop_ctrl.sv
module sim_swp_loop_ctrl;
  localparam int PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int RW = 6;
  localparam int NVEC = 6;
  // each entry: {trip count, stage count, effective trip count}
  localparam logic [47:0] VECS [NVEC] = '{
    {16'd4, 16'd4,  16'd4},
    {16'd1, 16'd1,  16'd1},
    {16'd1, 16'd3,  16'd1},
    {16'd5, 16'd1,  16'd5},
    {16'd3, 16'd10, 16'd3},
    {16'd0, 16'd2,  16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic br_i = 1'b0;
  logic [CW-1:0] trip_i = '0;
  logic [CW-1:0] stages_i = '0;
  logic taken_o, done_o;
  logic [PW-1:0] pred_o;
  logic [RW-1:0] rrb_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  swp_loop_ctrl #(.CNT_W(CW), .PRED_W(PW), .RRB_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .trip_i(trip_i),
    .stages_i(stages_i), .br_i(br_i), .taken_o(taken_o), .done_o(done_o),
    .pred_o(pred_o), .rrb_o(rrb_o)
  );

  function automatic logic [PW-1:0] pred_model(int p, int n);
    logic [PW-1:0] v = '0;
    for (int k = 0; k < PW; k++) v[k] = (p - k >= 0) && (p - k < n);
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(int n, int s, bit with_br);
    @(negedge clk);
    load_i = 1'b1; trip_i = CW'(n); stages_i = CW'(s); br_i = with_br;
    @(negedge clk);
    load_i = 1'b0; br_i = 1'b0;
  endtask

  task automatic do_branch();
    @(negedge clk);
    br_i = 1'b1;
    @(negedge clk);
    br_i = 1'b0;
  endtask

  task automatic run_loop(int n, int s, int neff, string tag);
    int total = neff + s - 1;
    chk(pred_o == 1, {tag, " R1 seed"}, pred_o, 1);
    chk(rrb_o == 0, {tag, " R1 base"}, rrb_o, 0);
    for (int b = 1; b <= total; b++) begin
      do_branch();
      if (b < total) begin
        chk(taken_o == 1'b1, {tag, " R2/R3 taken"}, taken_o, 1);
        chk(pred_o == pred_model(b, neff), {tag, " R5 pattern"}, pred_o, pred_model(b, neff));
        chk(rrb_o == RW'(-b), {tag, " R6 base"}, rrb_o, int'(RW'(-b)));
        chk(done_o == 1'b0, {tag, " R4 early done"}, done_o, 0);
      end else begin
        chk(taken_o == 1'b0, {tag, " R4/R7 fall-through"}, taken_o, 0);
        chk(done_o == 1'b1, {tag, " R4 done"}, done_o, 1);
      end
    end
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R4 pulse width"}, done_o, 0);
    // stray strobe after exit: ignored, state held
    do_branch();
    chk(taken_o == 1'b0, {tag, " R8 stray taken"}, taken_o, 0);
    chk(pred_o == pred_model(total - 1, neff), {tag, " R10 pred hold"}, pred_o, pred_model(total - 1, neff));
    chk(rrb_o == RW'(-(total - 1)), {tag, " R10 base hold"}, rrb_o, int'(RW'(-(total - 1))));
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(pred_o == 0, "R11 pred", pred_o, 0);
    chk(rrb_o == 0, "R11 base", rrb_o, 0);
    chk(taken_o == 0 && done_o == 0, "R11 flags", {taken_o, done_o}, 0);
    rst_n = 1'b1;
    // R8 strobe with no loop armed
    do_branch();
    chk(taken_o == 0 && done_o == 0, "R8 idle strobe", {taken_o, done_o}, 0);
    chk(pred_o == 0, "R8 idle pred", pred_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      int n = int'(VECS[v][47:32]);
      int s = int'(VECS[v][31:16]);
      int ne = int'(VECS[v][15:0]);
      do_load(n, s, 1'b0);
      run_loop(n, s, ne, $sformatf("vec%0d R7", v));
    end

    // R7 explicit pattern for N=4,S=4: P3..P0 as pred values
    do_load(4, 4, 1'b0);
    begin
      logic [3:0] exp_p [7] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111,
                               4'b1110, 4'b1100, 4'b1000};
      for (int p = 0; p < 7; p++) begin
        chk(pred_o[3:0] == exp_p[p], "R7 4x4 pattern", pred_o[3:0], exp_p[p]);
        do_branch();
      end
      chk(done_o == 1'b1, "R7 4x4 exit", done_o, 1);
    end

    // R9 reload together with strobe mid-loop
    do_load(6, 3, 1'b0);
    do_branch();
    do_branch();
    do_load(2, 2, 1'b1);
    chk(taken_o == 1'b0, "R9 load beats strobe", taken_o, 0);
    run_loop(2, 2, 2, "R9 reload");

    // R12 cycle count with II=2
    @(negedge clk);
    load_i = 1'b1; trip_i = 16'd100; stages_i = 16'd3;
    @(negedge clk);
    load_i = 1'b0;
    cyc = 0;
    while (!done_o && cyc < 400) begin
      cyc++;
      @(negedge clk);
      br_i = 1'b1; cyc++;
      @(negedge clk);
      br_i = 1'b0;
    end
    chk(cyc == 204, "R12 total cycles", cyc, 204);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule